// File: doc/BRIEF.md
# Keyed Configuration Item Reader

This block lets a host pull small configuration items out of a keyed table through two registers. The host writes a 16-bit key to a selector register. The key picks one item, and the byte offset into that item returns to zero. Each read of the data register then returns the next 1 to 8 bytes of the item, packed most-significant first. When the item runs out, the remaining low bytes of the read are zero. Once the whole item has been read, later reads return zero.

The table has two banks: a generic bank and an architecture-local bank. Each bank holds `FILE_FIRST + FILE_SLOTS` entries, which is 64 by default. Each entry stores up to `ITEM_BYTES` bytes and a length. Item contents come in through a side load port. After reset, generic entry 0 holds a 4-byte signature and generic entry 1 holds a 4-byte version word. A build option replaces the split register pair with one narrow combined port. On that port the access size tells a key write from a data access.

Top module: `cfgport_top`

## Requirements
- R1: After reset, the selection is generic key 0 with offset 0, and `rsp_valid` and `rsp_data` are 0. Generic item 0 has length 4 and holds bytes 0x51, 0x45, 0x4D, 0x55, so a 4-byte read right after reset returns 0x51454D55.
- R2: Generic item 1 has length 4. It is stored little-endian, with byte 0 equal to 0x01 | (DMA_EN << 1) and the other three bytes 0. With DMA_EN = 0, a 4-byte read returns 0x01000000.
- R3: Every accepted key write sets the byte offset to 0, even when it selects the item that is already selected.
- R4: Key bit 15 chooses the bank (0 = generic, 1 = local). Bits 13:0 form the entry index. Bit 14 is ignored.
- R5: A key whose bits 13:0 are at or above FILE_FIRST + FILE_SLOTS (64 by default) makes the selection invalid. Every data read then returns 0 until a valid key is written.
- R6: A data read of N bytes (1 to 8) puts item byte `offset+i` at bits `[(N-1-i)*8 +: 8]` of `rsp_data`. All bits above N*8 are 0, and the offset advances by one for each byte delivered.
- R7: If the item ends partway through a read, the bytes that are missing are 0. The offset stops at the item length.
- R8: A read with the offset at or past the item length returns 0 and leaves the offset unchanged. If the length is later extended, the next read delivers the byte at the old length.
- R9: A write to the data register, of any size, changes neither the selection nor the offset.
- R10: In split mode (COMBINED = 0), `req_addr` 0 is the selector and `req_addr` 1 is data. The selector accepts only 2-byte writes, and other writes to it are ignored. Reads of the selector, and data reads of size 0 or above 8, return 0 and do not move the offset.
- R11: In combined mode (COMBINED = 1), `req_addr` is ignored. A 2-byte write is a key write and a 1-byte read is a data read. Every other access moves nothing, and a read of another size returns 0.
- R12: `rsp_valid` is high in the cycle after each read request and low after every other cycle. `rsp_data` is registered at that same edge.
- R13: `ld_data_we` stores `ld_byte` at byte `ld_off` of entry `ld_idx` in bank `ld_bank`. `ld_len_we` sets that entry's length to `ld_len`, and any value above ITEM_BYTES is clamped to ITEM_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 1 | 0 = selector, 1 = data (split mode only) |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 16 | Key for selector writes |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 64 | Read data, packed big-endian in the low bytes |
| ld_data_we | input | 1 | Load one item byte |
| ld_len_we | input | 1 | Load an item length |
| ld_bank | input | 1 | Load target bank |
| ld_idx | input | 6 | Load target entry |
| ld_off | input | 3 | Load byte position |
| ld_byte | input | 8 | Load byte value |
| ld_len | input | 4 | Load length value |

## Verification
A corrupted offset shows up on the very next data read as shifted or repeated bytes. A wrong bank or index bit shows up in the first byte returned after a key write. A stuck invalid flag turns every later read into zeros. Because each read reply depends on the selection and offset from all earlier accesses, comparing every reply against a model catches any state error within one read.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam int RD_BYTES  = 8;
    localparam int KEY_W     = 16;
    localparam int IDX_BITS  = 14;
    localparam int LOCAL_BIT = 15;

    typedef logic [7:0] byte_t;
    typedef byte_t [RD_BYTES-1:0] win_t;

    typedef enum logic { BANK_GEN = 1'b0, BANK_LOCAL = 1'b1 } bank_e;

    typedef struct packed {
        logic                ok;
        bank_e               bank;
        logic [IDX_BITS-1:0] idx;
    } keydec_t;

    // contents of the table right after reset
    function automatic byte_t boot_byte(int bank, int ent, int pos, bit dma);
        byte_t v;
        v = 8'h00;
        if (bank == 0 && ent == 0) begin
            case (pos)
                0: v = 8'h51;
                1: v = 8'h45;
                2: v = 8'h4D;
                3: v = 8'h55;
                default: v = 8'h00;
            endcase
        end
        if (bank == 0 && ent == 1 && pos == 0) v = {6'b0, dma, 1'b1};
        return v;
    endfunction

    function automatic int boot_len(int bank, int ent);
        return (bank == 0 && ent < 2) ? 4 : 0;
    endfunction

    // first 'take' bytes of w, most significant first, inside an n-byte field
    function automatic logic [63:0] pack_be(win_t w, int take, int n);
        logic [63:0] v;
        v = '0;
        for (int i = 0; i < RD_BYTES; i++) begin
            if (i < take) v = v | ({56'b0, w[i]} << (8 * (n - 1 - i)));
        end
        return v;
    endfunction

endpackage

// File: rtl/cfgport_keydec.sv
module cfgport_keydec
    import cfgport_pkg::*;
#(
    parameter int NUM_ENT = 64
) (
    input  logic [KEY_W-1:0] key,
    output keydec_t          dec
);
    logic unused_key_b14;
    assign unused_key_b14 = key[14];

    always_comb begin
        dec.idx  = key[IDX_BITS-1:0];
        dec.bank = bank_e'(key[LOCAL_BIT]);
        dec.ok   = (32'(key[IDX_BITS-1:0]) < 32'(NUM_ENT));
    end
endmodule

// File: rtl/cfgport_store.sv
module cfgport_store
    import cfgport_pkg::*;
#(
    parameter int NUM_ENT    = 64,
    parameter int ITEM_BYTES = 8,
    parameter bit DMA_EN     = 1'b0,
    localparam int ENT_W     = $clog2(NUM_ENT),
    localparam int BYTE_W    = (ITEM_BYTES > 1) ? $clog2(ITEM_BYTES) : 1,
    localparam int LEN_W     = $clog2(ITEM_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_data_we,
    input  logic              ld_len_we,
    input  logic              ld_bank,
    input  logic [ENT_W-1:0]  ld_idx,
    input  logic [BYTE_W-1:0] ld_off,
    input  logic [7:0]        ld_byte,
    input  logic [LEN_W-1:0]  ld_len,
    input  bank_e             rd_bank,
    input  logic [ENT_W-1:0]  rd_idx,
    input  logic [LEN_W-1:0]  rd_off,
    output win_t              win,
    output logic [LEN_W-1:0]  rd_len
);
    byte_t            mem   [2][NUM_ENT][ITEM_BYTES];
    logic [LEN_W-1:0] len_q [2][NUM_ENT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < 2; b++) begin
                for (int e = 0; e < NUM_ENT; e++) begin
                    len_q[b][e] <= LEN_W'(boot_len(b, e));
                    for (int p = 0; p < ITEM_BYTES; p++)
                        mem[b][e][p] <= boot_byte(b, e, p, DMA_EN);
                end
            end
        end else begin
            if (ld_data_we && 32'(ld_idx) < 32'(NUM_ENT) && 32'(ld_off) < 32'(ITEM_BYTES))
                mem[ld_bank][ld_idx][ld_off] <= ld_byte;
            if (ld_len_we && 32'(ld_idx) < 32'(NUM_ENT))
                len_q[ld_bank][ld_idx] <= (32'(ld_len) > 32'(ITEM_BYTES)) ?
                                          LEN_W'(ITEM_BYTES) : ld_len;
        end
    end

    assign rd_len = len_q[rd_bank][rd_idx];

    // one lane per byte of the widest read, starting at the current offset
    for (genvar i = 0; i < RD_BYTES; i++) begin : g_lane
        assign win[i] = (32'(rd_off) + i < ITEM_BYTES) ?
                        mem[rd_bank][rd_idx][BYTE_W'(32'(rd_off) + i)] : 8'h00;
    end
endmodule

// File: rtl/cfgport_sel.sv
module cfgport_sel
    import cfgport_pkg::*;
#(
    parameter int NUM_ENT    = 64,
    parameter int ITEM_BYTES = 8,
    localparam int ENT_W     = $clog2(NUM_ENT),
    localparam int LEN_W     = $clog2(ITEM_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_fire,
    input  keydec_t          dec,
    input  logic             rd_any,
    input  logic             rd_fire,
    input  logic [3:0]       rd_n,
    input  win_t             win,
    input  logic [LEN_W-1:0] item_len,
    output bank_e            sel_bank,
    output logic [ENT_W-1:0] sel_idx,
    output logic [LEN_W-1:0] cur_off,
    output logic [63:0]      rsp_data
);
    logic                sel_valid;
    int                  avail;
    int                  take;
    logic [IDX_BITS-1:0] unused_idx;
    assign unused_idx = dec.idx;

    always_comb begin
        avail = (sel_valid && cur_off < item_len) ? int'(item_len - cur_off) : 0;
        take  = (avail < int'(rd_n)) ? avail : int'(rd_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_valid <= 1'b1;
            sel_bank  <= BANK_GEN;
            sel_idx   <= '0;
            cur_off   <= '0;
            rsp_data  <= '0;
        end else begin
            if (sel_fire) begin
                sel_valid <= dec.ok;
                sel_bank  <= dec.bank;
                sel_idx   <= dec.idx[ENT_W-1:0];
                cur_off   <= '0;
            end
            if (rd_any)
                rsp_data <= rd_fire ? pack_be(win, take, int'(rd_n)) : 64'd0;
            if (rd_fire)
                cur_off <= cur_off + LEN_W'(take);
        end
    end

    // R3
    off_clear_chk: assert property (@(posedge clk) disable iff (rst)
        sel_fire |=> cur_off == '0);
    // R8
    end_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_fire && (!sel_valid || cur_off >= item_len) |=> rsp_data == 64'd0 && $stable(cur_off));
    // R6
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        rd_fire && sel_valid && cur_off < item_len |=> cur_off > $past(cur_off));
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_fire && !rd_fire |=> $stable(cur_off) && $stable(sel_valid) && $stable(sel_idx));
    // R7
    off_bound_chk: assert property (@(posedge clk) disable iff (rst)
        32'(cur_off) <= 32'(ITEM_BYTES));
endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
    import cfgport_pkg::*;
#(
    parameter int FILE_FIRST = 32,
    parameter int FILE_SLOTS = 32,
    parameter int ITEM_BYTES = 8,
    parameter bit DMA_EN     = 1'b0,
    parameter bit COMBINED   = 1'b0,
    localparam int NUM_ENT   = FILE_FIRST + FILE_SLOTS,
    localparam int ENT_W     = $clog2(NUM_ENT),
    localparam int BYTE_W    = (ITEM_BYTES > 1) ? $clog2(ITEM_BYTES) : 1,
    localparam int LEN_W     = $clog2(ITEM_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_addr,
    input  logic [3:0]        req_size,
    input  logic [15:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_data,
    input  logic              ld_data_we,
    input  logic              ld_len_we,
    input  logic              ld_bank,
    input  logic [ENT_W-1:0]  ld_idx,
    input  logic [BYTE_W-1:0] ld_off,
    input  logic [7:0]        ld_byte,
    input  logic [LEN_W-1:0]  ld_len
);
    logic             sel_fire;
    logic             rd_any;
    logic             rd_fire;
    logic [3:0]       rd_n;
    keydec_t          dec;
    bank_e            sel_bank;
    logic [ENT_W-1:0] sel_idx;
    logic [LEN_W-1:0] cur_off;
    logic [LEN_W-1:0] item_len;
    win_t             win;

    assign rd_any = req_valid && !req_write;

    if (COMBINED) begin : g_comb
        logic unused_addr;
        assign unused_addr = req_addr;
        assign sel_fire = req_valid && req_write && req_size == 4'd2;
        assign rd_fire  = rd_any && req_size == 4'd1;
        assign rd_n     = 4'd1;
    end else begin : g_split
        assign sel_fire = req_valid && req_write && !req_addr && req_size == 4'd2;
        assign rd_fire  = rd_any && req_addr && req_size != 4'd0 &&
                          32'(req_size) <= 32'(RD_BYTES);
        assign rd_n     = req_size;
    end

    cfgport_keydec #(.NUM_ENT(NUM_ENT)) u_dec (
        .key (req_wdata),
        .dec (dec)
    );

    cfgport_store #(.NUM_ENT(NUM_ENT), .ITEM_BYTES(ITEM_BYTES), .DMA_EN(DMA_EN)) u_store (
        .clk        (clk),
        .rst        (rst),
        .ld_data_we (ld_data_we),
        .ld_len_we  (ld_len_we),
        .ld_bank    (ld_bank),
        .ld_idx     (ld_idx),
        .ld_off     (ld_off),
        .ld_byte    (ld_byte),
        .ld_len     (ld_len),
        .rd_bank    (sel_bank),
        .rd_idx     (sel_idx),
        .rd_off     (cur_off),
        .win        (win),
        .rd_len     (item_len)
    );

    cfgport_sel #(.NUM_ENT(NUM_ENT), .ITEM_BYTES(ITEM_BYTES)) u_sel (
        .clk      (clk),
        .rst      (rst),
        .sel_fire (sel_fire),
        .dec      (dec),
        .rd_any   (rd_any),
        .rd_fire  (rd_fire),
        .rd_n     (rd_n),
        .win      (win),
        .item_len (item_len),
        .sel_bank (sel_bank),
        .sel_idx  (sel_idx),
        .cur_off  (cur_off),
        .rsp_data (rsp_data)
    );

    always_ff @(posedge clk) begin
        if (rst) rsp_valid <= 1'b0;
        else     rsp_valid <= rd_any;
    end
endmodule

// File: tb/sim_cfgport_top.sv
module sim_cfgport_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 0, req_write = 0, req_addr = 0;
    logic [3:0]  req_size = 0;
    logic [15:0] req_wdata = 0;
    logic        c_req_valid = 0, c_req_write = 0, c_req_addr = 0;
    logic [3:0]  c_req_size = 0;
    logic [15:0] c_req_wdata = 0;
    logic        rsp_valid, c_rsp_valid;
    logic [63:0] rsp_data, c_rsp_data;
    logic        ld_data_we = 0, ld_len_we = 0, ld_bank = 0;
    logic [5:0]  ld_idx = 0;
    logic [2:0]  ld_off = 0;
    logic [7:0]  ld_byte = 0;
    logic [3:0]  ld_len = 0;

    int n_chk = 0;
    int n_bad = 0;

    always #2ns clk = ~clk;

    cfgport_top u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .ld_data_we(ld_data_we), .ld_len_we(ld_len_we), .ld_bank(ld_bank),
        .ld_idx(ld_idx), .ld_off(ld_off), .ld_byte(ld_byte), .ld_len(ld_len)
    );

    cfgport_top #(.COMBINED(1'b1)) u1 (
        .clk(clk), .rst(rst), .req_valid(c_req_valid), .req_write(c_req_write),
        .req_addr(c_req_addr), .req_size(c_req_size), .req_wdata(c_req_wdata),
        .rsp_valid(c_rsp_valid), .rsp_data(c_rsp_data),
        .ld_data_we(ld_data_we), .ld_len_we(ld_len_we), .ld_bank(ld_bank),
        .ld_idx(ld_idx), .ld_off(ld_off), .ld_byte(ld_byte), .ld_len(ld_len)
    );

    // reference model of the split-mode instance
    logic [7:0] m_mem [2][64][8];
    int         m_len [2][64];
    bit         m_valid;
    int         m_bank, m_idx, m_off;

    function automatic void m_reset();
        for (int b = 0; b < 2; b++)
            for (int e = 0; e < 64; e++) begin
                m_len[b][e] = (b == 0 && e < 2) ? 4 : 0;
                for (int p = 0; p < 8; p++) m_mem[b][e][p] = 8'h00;
            end
        m_mem[0][0][0] = 8'h51; m_mem[0][0][1] = 8'h45;
        m_mem[0][0][2] = 8'h4D; m_mem[0][0][3] = 8'h55;
        m_mem[0][1][0] = 8'h01;
        m_valid = 1; m_bank = 0; m_idx = 0; m_off = 0;
    endfunction

    function automatic logic [63:0] m_access(bit w, bit a, int sz, logic [15:0] wd);
        logic [63:0] v;
        v = '0;
        if (w) begin
            if (!a && sz == 2) begin
                m_off = 0;
                m_valid = (int'(wd[13:0]) < 64);
                m_bank = int'(wd[15]);
                m_idx = int'(wd[5:0]);
            end
        end else if (a && sz >= 1 && sz <= 8) begin
            for (int i = 0; i < sz; i++) begin
                if (m_valid && m_off < m_len[m_bank][m_idx]) begin
                    v[(sz - 1 - i) * 8 +: 8] = m_mem[m_bank][m_idx][m_off];
                    m_off++;
                end
            end
        end
        return v;
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(bit w, bit a, int sz, logic [15:0] wd, string tag, output logic [63:0] d);
        logic [63:0] exp;
        exp = m_access(w, a, sz, wd);
        req_valid = 1; req_write = w; req_addr = a; req_size = sz[3:0]; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        d = rsp_data;
        // R12
        chk(rsp_valid == !w, "R12", {63'b0, rsp_valid}, {63'b0, !w});
        if (!w) chk(d == exp, tag, d, exp);
    endtask

    task automatic cacc(bit w, int sz, logic [15:0] wd, output logic [63:0] d, output bit v);
        c_req_valid = 1; c_req_write = w; c_req_addr = $urandom_range(0, 1); c_req_size = sz[3:0];
        c_req_wdata = wd;
        @(negedge clk);
        c_req_valid = 0;
        d = c_rsp_data; v = c_rsp_valid;
    endtask

    task automatic ldb(int b, int e, int p, logic [7:0] val);
        ld_data_we = 1; ld_bank = b[0]; ld_idx = e[5:0]; ld_off = p[2:0]; ld_byte = val;
        m_mem[b][e][p] = val;
        @(negedge clk);
        ld_data_we = 0;
    endtask

    task automatic ldl(int b, int e, int len);
        ld_len_we = 1; ld_bank = b[0]; ld_idx = e[5:0]; ld_len = len[3:0];
        m_len[b][e] = (len > 8) ? 8 : len;
        @(negedge clk);
        ld_len_we = 0;
    endtask

    initial begin
        #(4ns * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] d;
        bit          v;
        void'($urandom(32'd7341));
        m_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk(rsp_valid == 0 && rsp_data == 0, "R1", rsp_data, 64'd0);
        acc(0, 1, 4, 0, "R1", d);
        chk(d == 64'h51454D55, "R1", d, 64'h51454D55);
        acc(0, 1, 1, 0, "R8", d);
        chk(d == 0, "R8", d, 0);
        // R2 version item
        acc(1, 0, 2, 16'h0001, "R2", d);
        acc(0, 1, 4, 0, "R2", d);
        chk(d == 64'h01000000, "R2", d, 64'h01000000);
        // R3 reselect restarts
        acc(1, 0, 2, 16'h0000, "R3", d);
        acc(0, 1, 2, 0, "R3", d);
        chk(d == 64'h5145, "R3", d, 64'h5145);
        acc(1, 0, 2, 16'h0000, "R3", d);
        acc(0, 1, 1, 0, "R3", d);
        chk(d == 64'h51, "R3", d, 64'h51);
        // R4 banks and ignored bit 14
        ldb(1, 5, 0, 8'hAA); ldb(1, 5, 1, 8'hBB); ldl(1, 5, 2);
        ldb(0, 5, 0, 8'hCC); ldl(0, 5, 1);
        acc(1, 0, 2, 16'h8005, "R4", d);
        acc(0, 1, 2, 0, "R4", d);
        chk(d == 64'hAABB, "R4", d, 64'hAABB);
        acc(1, 0, 2, 16'h4005, "R4", d);
        acc(0, 1, 1, 0, "R4", d);
        chk(d == 64'hCC, "R4", d, 64'hCC);
        acc(1, 0, 2, 16'hC005, "R4", d);
        acc(0, 1, 1, 0, "R4", d);
        chk(d == 64'hAA, "R4", d, 64'hAA);
        // R7 short item padding
        acc(1, 0, 2, 16'h8005, "R7", d);
        acc(0, 1, 4, 0, "R7", d);
        chk(d == 64'hAABB0000, "R7", d, 64'hAABB0000);
        // R8 offset holds at the end
        acc(0, 1, 3, 0, "R8", d);
        chk(d == 0, "R8", d, 0);
        ldb(1, 5, 2, 8'h77); ldl(1, 5, 3);
        acc(0, 1, 1, 0, "R8", d);
        chk(d == 64'h77, "R8", d, 64'h77);
        // R5 range check
        ldb(0, 63, 0, 8'h5A); ldl(0, 63, 1);
        acc(1, 0, 2, 16'h0040, "R5", d);
        acc(0, 1, 8, 0, "R5", d);
        chk(d == 0, "R5", d, 0);
        acc(1, 0, 2, 16'h3FFF, "R5", d);
        acc(0, 1, 2, 0, "R5", d);
        chk(d == 0, "R5", d, 0);
        acc(1, 0, 2, 16'h003F, "R5", d);
        acc(0, 1, 1, 0, "R5", d);
        chk(d == 64'h5A, "R5", d, 64'h5A);
        // R9 data writes do nothing
        acc(1, 0, 2, 16'h0000, "R9", d);
        acc(0, 1, 1, 0, "R9", d);
        acc(1, 1, 1, 16'h00FF, "R9", d);
        acc(0, 1, 1, 0, "R9", d);
        chk(d == 64'h45, "R9", d, 64'h45);
        acc(1, 1, 4, 16'h1234, "R9", d);
        acc(0, 1, 1, 0, "R9", d);
        chk(d == 64'h4D, "R9", d, 64'h4D);
        // R10 split-mode access rules
        acc(1, 0, 1, 16'h0001, "R10", d);
        acc(0, 1, 1, 0, "R10", d);
        chk(d == 64'h55, "R10", d, 64'h55);
        acc(1, 0, 2, 16'h0000, "R10", d);
        acc(0, 0, 2, 0, "R10", d);
        chk(d == 0, "R10", d, 0);
        acc(0, 1, 0, 0, "R10", d);
        acc(0, 1, 9, 0, "R10", d);
        chk(d == 0, "R10", d, 0);
        acc(0, 1, 8, 0, "R6", d);
        chk(d == 64'h51454D5500000000, "R6", d, 64'h51454D5500000000);
        // R6 multi-byte packing, R13 length clamp
        for (int p = 0; p < 8; p++) ldb(0, 7, p, 8'(p + 1));
        ldl(0, 7, 8);
        acc(1, 0, 2, 16'h0007, "R6", d);
        acc(0, 1, 3, 0, "R6", d);
        chk(d == 64'h010203, "R6", d, 64'h010203);
        acc(0, 1, 5, 0, "R6", d);
        chk(d == 64'h0405060708, "R6", d, 64'h0405060708);
        ldl(0, 7, 2);
        ldl(0, 7, 15);
        acc(1, 0, 2, 16'h0007, "R13", d);
        acc(0, 1, 8, 0, "R13", d);
        chk(d == 64'h0102030405060708, "R13", d, 64'h0102030405060708);
        // R11 combined port
        cacc(0, 1, 0, d, v);
        chk(v && d == 64'h51, "R11", d, 64'h51);
        cacc(0, 2, 0, d, v);
        chk(v && d == 0, "R11", d, 0);
        cacc(0, 1, 0, d, v);
        chk(d == 64'h45, "R11", d, 64'h45);
        cacc(1, 1, 16'h0001, d, v);
        chk(!v, "R11", {63'b0, v}, 0);
        cacc(0, 1, 0, d, v);
        chk(d == 64'h4D, "R11", d, 64'h4D);
        cacc(1, 2, 16'h0001, d, v);
        cacc(0, 1, 0, d, v);
        chk(d == 64'h01, "R11", d, 64'h01);
        // random phase against the model
        for (int e = 2; e < 64; e++)
            for (int b = 0; b < 2; b++) begin
                for (int p = 0; p < 8; p++) ldb(b, e, p, 8'($urandom));
                ldl(b, e, $urandom_range(0, 9));
            end
        for (int it = 0; it < 800; it++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 2) begin
                logic [15:0] k;
                k = {1'($urandom), 1'($urandom), 14'($urandom_range(0, 70))};
                acc(1, 0, 2, k, "R4", d);
            end else if (r < 6) begin
                acc(0, 1, $urandom_range(1, 8), 0, "R6", d);
            end else if (r == 6) begin
                ldb($urandom_range(0, 1), $urandom_range(2, 63), $urandom_range(0, 7), 8'($urandom));
            end else if (r == 7) begin
                ldl($urandom_range(0, 1), $urandom_range(2, 63), $urandom_range(0, 15));
            end else if (r == 8) begin
                acc(1, 1, $urandom_range(1, 8), 16'($urandom), "R9", d);
            end else begin
                int s;
                s = ($urandom_range(0, 1) == 0) ? 0 : 9 + $urandom_range(0, 6);
                if ($urandom_range(0, 1) == 0) acc(1, 0, 1 + 2 * $urandom_range(0, 1) + 1, 16'($urandom), "R10", d);
                else acc(0, $urandom_range(0, 1) == 0 ? 1'b0 : 1'b1, s, 0, "R10", d);
            end
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule